// File: doc/BRIEF.md
# Ethernet MAC Control/Status Register Bank with Interrupts and Soft Reset

This block is the register bank of a DMA Ethernet MAC. It holds the command word, the interrupt enable and interrupt status words, the transmit and receive descriptor list pointers, a few configuration words, and the address filter enable and compare words. A host reaches it through a word-indexed slave port. A write strobe with data writes a word in the same cycle. A read strobe returns the selected word on `host_rdata` one cycle later. The transmit and receive engines report events on a 32-bit pulse vector. Each pulse sets the matching bit in the status word. The host clears status bits by writing ones to them.

The status word has two halves. Bits 31:16 carry transmit events and feed the transmit interrupt line. Bits 15:0 carry receive events and feed the receive interrupt line. A line is high when any status bit in its half is set and its enable bit is also set.

Setting bit 24 of the command word starts a soft reset. The reset is run by a three-state sequencer:
- **RUN** is normal operation.
- **RUN → BLANK** is taken on a command write with bit 24 set. In BLANK, every read returns zero, all words are held at their reset values, and `eng_rst` is high so that the descriptor engines restart.
- **BLANK → SETTLE** is taken after `BLANK_CYC` cycles. In SETTLE, reads return the reset values again, and the command word still shows bit 24 set.
- **SETTLE → RUN** is taken after `SETTLE_CYC` cycles. At that point bit 24 reads as zero.

Top module: `maccsr_bank`

## Requirements
- R1: After a hardware reset, reads return the reset values:
  - 0xFFFFFFFC for the transmit list pointer (index 3) and the receive list pointer (index 4).
  - 0x00900000 for the management word (index 5).
  - 0x00000101 for the FIFO threshold (index 6).
  - 0x00000800 for the receive maximum length (index 7).
  - 0x00007FFF for the missed-frame count (index 8).
  - Zero for the command word (0), the interrupt enable (1), the interrupt status (2), the filter compare control (9) and the filter enable (10).
  - Both interrupt lines are low and `eng_rst` is low.
- R2: A command write with bit 24 set makes every read captured in the following `BLANK_CYC` (16) cycles return zero.
- R3: For the next `SETTLE_CYC` (4) cycles, the command word reads 0x01000000 and the other words read their reset values. From the cycle after that, bit 24 reads 0.
- R4: A soft reset returns every word to its reset value. This includes the status word, the interrupt enable and both filter words. Both interrupt lines are low and `eng_rst` is high for the whole reset.
- R5: Host writes and event pulses that arrive during a soft reset have no effect.
- R6: An event pulse sets only the implemented status bits. These are:
  - Transmit bits 24, 23, 18 and 16.
  - Receive bits 11, 10, 9, 8, 4, 3 and 0.
  - All other status bits read 0, so setting every input bit reads back 0x01850F19.
- R7: Writing the status word (index 2) clears each bit that is 1 in the write data. Writing 0xFFFF0000 clears the transmit half and leaves the receive half unchanged. When an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R8: `irq_tx` is high exactly when some bit in 31:16 is set in both the status and the enable word. `irq_rx` is the same for bits 15:0.
- R9: In RUN, the words other than status store and read back the written value. A command write with bit 24 clear reads back unchanged.
- R10: Reads of indices 11 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_idx | input | IDX_W (4) | Word index for the read or write |
| host_we | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rd | input | 1 | Read strobe; data appears one cycle later |
| host_rdata | output | 32 | Read data |
| evt_set | input | 32 | Event pulses from the engines, one per status bit |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| eng_rst | output | 1 | High while a soft reset runs |

## Verification
The assertions check the following on every cycle:
- Reads captured in BLANK return zero.
- The sequencer moves only RUN → BLANK → SETTLE → RUN.
- The interrupt lines stay low and the enable word stays put during a reset.
- A write-one-to-clear with no competing event leaves the written bits clear.
- Neither line rises unless its half of the enable word has a bit set.

Only the bench scenarios can show the exact cycle boundaries of the blank and settle windows, the reset value of each word, the set-wins-over-clear ordering, and the split of events between the two interrupt lines.

// File: rtl/maccsr_pkg.sv
package maccsr_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_BLANK  = 2'd1,
        ST_SETTLE = 2'd2
    } rst_state_e;

    localparam int unsigned SR_BIT = 24;
    localparam logic [31:0] STS_MASK = 32'h0185_0F19;

    localparam int unsigned IX_CMD    = 0;
    localparam int unsigned IX_IEN    = 1;
    localparam int unsigned IX_STS    = 2;
    localparam int unsigned IX_TXLIST = 3;
    localparam int unsigned IX_RXLIST = 4;
    localparam int unsigned IX_MGMT   = 5;
    localparam int unsigned IX_FIFO   = 6;
    localparam int unsigned IX_RXMAX  = 7;
    localparam int unsigned IX_MISS   = 8;
    localparam int unsigned IX_CAMCTL = 9;
    localparam int unsigned IX_CAMEN  = 10;
    localparam int unsigned NREG      = 11;

    function automatic logic [31:0] reg_default(int unsigned ix);
        case (ix)
            IX_TXLIST, IX_RXLIST: return 32'hFFFF_FFFC;
            IX_MGMT:              return 32'h0090_0000;
            IX_FIFO:              return 32'h0000_0101;
            IX_RXMAX:             return 32'h0000_0800;
            IX_MISS:              return 32'h0000_7FFF;
            default:              return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/maccsr_rst_fsm.sv
module maccsr_rst_fsm
    import maccsr_pkg::*;
#(
    parameter int unsigned BLANK_CYC  = 16,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_req,
    output rst_state_e state,
    output logic       busy
);
    localparam int unsigned MAXC = (BLANK_CYC > SETTLE_CYC) ? BLANK_CYC : SETTLE_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    rst_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (sr_req) begin
                    state_d = ST_BLANK;
                    cnt_d   = '0;
                end
            end
            ST_BLANK: begin
                if (cnt_q == CW'(BLANK_CYC - 1)) begin
                    state_d = ST_SETTLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == CW'(SETTLE_CYC - 1)) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state = state_q;
        busy  = (state_q != ST_RUN);
    end

    // R3
    blank_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK) |=> (state_q == ST_BLANK || state_q == ST_SETTLE));

    // R3
    settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |=> (state_q == ST_SETTLE || state_q == ST_RUN));

    // R2
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !sr_req) |=> (state_q == ST_RUN));

endmodule

// File: rtl/maccsr_irq_status.sv
module maccsr_irq_status
    import maccsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_all,
    input  logic        w1c_en,
    input  logic [31:0] w1c_data,
    input  logic [31:0] evt,
    input  logic [31:0] ien,
    output logic [31:0] sts,
    output logic        irq_tx,
    output logic        irq_rx
);
    logic [31:0] sts_q;
    logic [31:0] clr_mask;

    always_comb clr_mask = w1c_en ? w1c_data : 32'h0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else if (clr_all) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_mask) | (evt & STS_MASK);
        end
    end

    always_comb begin
        sts    = sts_q;
        irq_tx = |(sts_q[31:16] & ien[31:16]);
        irq_rx = |(sts_q[15:0]  & ien[15:0]);
    end

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_en && !clr_all && ((evt & w1c_data) == 32'h0))
        |=> ((sts_q & $past(w1c_data)) == 32'h0));

    // R8
    tx_line_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> (ien[31:16] != 16'h0));

    // R8
    rx_line_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> (ien[15:0] != 16'h0));

endmodule

// File: rtl/maccsr_bank.sv
module maccsr_bank
    import maccsr_pkg::*;
#(
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned BLANK_CYC  = 16,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] host_idx,
    input  logic             host_we,
    input  logic [31:0]      host_wdata,
    input  logic             host_rd,
    output logic [31:0]      host_rdata,
    input  logic [31:0]      evt_set,
    output logic             irq_tx,
    output logic             irq_rx,
    output logic             eng_rst
);
    rst_state_e  state;
    logic        busy;
    logic        wr_ok;
    logic        sr_req;
    logic        w1c_en;
    logic [31:0] sts;
    logic [31:0] rd_val;
    logic [31:0] rdata_q;
    logic [NREG-1:0][31:0] reg_q;

    always_comb begin
        wr_ok  = host_we && (state == ST_RUN);
        sr_req = wr_ok && (host_idx == IDX_W'(IX_CMD)) && host_wdata[SR_BIT];
        w1c_en = wr_ok && (host_idx == IDX_W'(IX_STS));
    end

    maccsr_rst_fsm #(
        .BLANK_CYC (BLANK_CYC),
        .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .sr_req(sr_req),
        .state (state),
        .busy  (busy)
    );

    maccsr_irq_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (busy || sr_req),
        .w1c_en  (w1c_en),
        .w1c_data(host_wdata),
        .evt     (evt_set),
        .ien     (reg_q[IX_IEN]),
        .sts     (sts),
        .irq_tx  (irq_tx),
        .irq_rx  (irq_rx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) reg_q[i] <= reg_default(i);
        end else if (busy || sr_req) begin
            for (int i = 0; i < NREG; i++) reg_q[i] <= reg_default(i);
        end else if (wr_ok) begin
            for (int i = 0; i < NREG; i++) begin
                if (i != IX_STS && host_idx == IDX_W'(i)) reg_q[i] <= host_wdata;
            end
        end
    end

    always_comb begin
        rd_val = 32'h0;
        for (int i = 0; i < NREG; i++) begin
            if (host_idx == IDX_W'(i)) begin
                if (i == IX_STS)
                    rd_val = sts;
                else if (i == IX_CMD)
                    rd_val = reg_q[i] | ((state == ST_SETTLE) ? (32'h1 << SR_BIT) : 32'h0);
                else
                    rd_val = reg_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (host_rd) begin
            rdata_q <= (state == ST_BLANK) ? 32'h0 : rd_val;
        end
    end

    always_comb begin
        host_rdata = rdata_q;
        eng_rst    = busy;
    end

    // R2
    blank_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && state == ST_BLANK) |=> (host_rdata == 32'h0));

    // R4
    rst_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst |-> (!irq_tx && !irq_rx));

    // R5
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we) |=> $stable(reg_q[IX_IEN]));

    // R3
    cmd_bit_clear_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_rst) |-> !reg_q[IX_CMD][SR_BIT]);

endmodule

// File: tb/sim_maccsr_bank.sv
`timescale 1ns/1ps
module sim_maccsr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_idx = '0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic [31:0] evt_set = '0;
    logic        irq_tx, irq_rx, eng_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    maccsr_bank u0 (
        .clk(clk), .rst_n(rst_n), .host_idx(host_idx), .host_we(host_we),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .evt_set(evt_set), .irq_tx(irq_tx), .irq_rx(irq_rx), .eng_rst(eng_rst)
    );

    // monitor: pops one expected word per captured read
    initial begin
        forever begin
            logic pend;
            @(posedge clk);
            pend = host_rd && rst_n;
            #1;
            if (pend) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (host_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s read: actual %h expected %h", t, host_rdata, e);
                end
            end
        end
    end

    task automatic drv_idle();
        @(negedge clk);
        host_we = 0; host_rd = 0; evt_set = '0;
    endtask

    task automatic drv_wr(input logic [3:0] ix, input logic [31:0] d, input logic [31:0] ev);
        @(negedge clk);
        host_we = 1; host_rd = 0; host_idx = ix; host_wdata = d; evt_set = ev;
    endtask

    task automatic drv_evt(input logic [31:0] ev);
        @(negedge clk);
        host_we = 0; host_rd = 0; evt_set = ev;
    endtask

    task automatic drv_rd(input logic [3:0] ix, input logic [31:0] e, input string t);
        @(negedge clk);
        host_we = 0; host_rd = 1; host_idx = ix; evt_set = '0;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        n_chk++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", t, act, e);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drv_idle();
        // R1 reset values
        drv_rd(0,  32'h0000_0000, "R1 cmd");
        drv_rd(1,  32'h0000_0000, "R1 ien");
        drv_rd(2,  32'h0000_0000, "R1 sts");
        drv_rd(3,  32'hFFFF_FFFC, "R1 txlist");
        drv_rd(4,  32'hFFFF_FFFC, "R1 rxlist");
        drv_rd(5,  32'h0090_0000, "R1 mgmt");
        drv_rd(6,  32'h0000_0101, "R1 fifo");
        drv_rd(7,  32'h0000_0800, "R1 rxmax");
        drv_rd(8,  32'h0000_7FFF, "R1 miss");
        drv_rd(9,  32'h0000_0000, "R1 camctl");
        drv_rd(10, 32'h0000_0000, "R1 camen");
        drv_rd(12, 32'h0000_0000, "R10 idx12");
        drv_rd(15, 32'h0000_0000, "R10 idx15");
        drv_idle();
        chk_bit(irq_tx, 0, "R1 irq_tx");
        chk_bit(irq_rx, 0, "R1 irq_rx");
        chk_bit(eng_rst, 0, "R1 eng_rst");

        // R9 read-back
        drv_wr(1, 32'h0005_0011, 0);
        drv_wr(3, 32'h0000_1000, 0);
        drv_rd(1, 32'h0005_0011, "R9 ien");
        drv_rd(3, 32'h0000_1000, "R9 txlist");
        drv_idle();

        // R6 event mask
        drv_evt(32'hFFFF_FFFF);
        drv_idle();
        chk_bit(irq_tx, 1, "R8 tx high");
        chk_bit(irq_rx, 1, "R8 rx high");
        drv_rd(2, 32'h0185_0F19, "R6 mask");

        // R7 upper-half clear
        drv_wr(2, 32'hFFFF_0000, 0);
        drv_idle();
        chk_bit(irq_tx, 0, "R7 tx cleared");
        chk_bit(irq_rx, 1, "R7 rx kept");
        drv_rd(2, 32'h0000_0F19, "R7 upper clear");

        // R8 enable gating on receive half
        drv_wr(1, 32'h0000_0010, 0);
        drv_wr(2, 32'h0000_0010, 0);
        drv_idle();
        chk_bit(irq_rx, 0, "R8 rx gated");
        drv_rd(2, 32'h0000_0F09, "R7 single clear");

        // R7 set wins over clear
        drv_wr(2, 32'h0000_0008, 32'h0000_0008);
        drv_idle();
        drv_rd(2, 32'h0000_0F09, "R7 set wins");

        // R8 transmit side
        drv_wr(1, 32'h0004_0000, 0);
        drv_idle();
        chk_bit(irq_tx, 0, "R8 tx idle");
        drv_evt(32'h0004_0000);
        drv_idle();
        chk_bit(irq_tx, 1, "R8 tx complete");
        chk_bit(irq_rx, 0, "R8 rx no enable");

        // R4 prepare non-default words
        drv_wr(10, 32'h0000_0001, 0);
        drv_wr(9,  32'h0000_0011, 0);
        drv_wr(6,  32'h0000_0055, 0);
        drv_idle();

        // R2 soft reset
        drv_wr(0, 32'h0100_0101, 0);
        drv_rd(0, 32'h0, "R2 blank cmd");
        chk_bit(eng_rst, 1, "R4 eng_rst");
        chk_bit(irq_tx, 0, "R4 irq_tx quiet");
        drv_rd(3, 32'h0, "R2 blank txlist");
        drv_rd(6, 32'h0, "R2 blank fifo");
        drv_rd(7, 32'h0, "R2 blank rxmax");
        drv_wr(1, 32'hFFFF_FFFF, 0);
        drv_evt(32'hFFFF_FFFF);
        for (int j = 0; j < 10; j++) drv_rd(4'(j), 32'h0, "R2 blank");
        drv_rd(0, 32'h0100_0000, "R3 settle cmd");
        chk_bit(eng_rst, 1, "R4 eng_rst settle");
        drv_rd(6, 32'h0000_0101, "R3 settle fifo");
        drv_rd(10, 32'h0, "R3 settle camen");
        drv_rd(0, 32'h0100_0000, "R3 settle cmd last");
        drv_rd(0, 32'h0, "R3 cmd cleared");
        drv_rd(1, 32'h0, "R5 ien ignored");
        drv_rd(2, 32'h0, "R5 sts ignored");
        drv_rd(9, 32'h0, "R4 camctl");
        drv_rd(3, 32'hFFFF_FFFC, "R4 txlist");
        drv_idle();
        chk_bit(eng_rst, 0, "R4 eng_rst low");
        chk_bit(irq_rx, 0, "R4 irq_rx low");

        // R9 command word after reset
        drv_wr(0, 32'h0000_0101, 0);
        drv_rd(0, 32'h0000_0101, "R9 cmd");
        drv_idle();
        drv_idle();
        drv_idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule